// File: doc/BRIEF.md
# Interruptible GPIO Bank

This block is a bank of general-purpose pins with a small word-addressed register interface. Software chooses each pin's direction and output level. Any pin can be handed to a peripheral signal instead. Two override modes replace the normal levels: a sleep mode, requested by a pin or enabled permanently through a configuration bit, and a battery-fault mode.

The input pins pass through a two-flop synchroniser. Each pin has its own detector, configured for a level or an edge of either polarity. A detected event sets a sticky status bit, and software clears that bit by writing a one to it. The status bits whose mask bit is clear are ORed into a single bank interrupt line.

The register port is plain control. It accepts a write on every cycle, and it returns read data in the same cycle from the address alone. There is no back-pressure at any edge of the block.

Top module: `gpio_irq_bank`

## Requirements
- R1: Reset state. While `rst_n` is low, and immediately after it, `pin_out`, `pin_oe` and `irq` are all zero. The mask register reads all ones and every other register reads zero.
- R2: Register map by byte address.
  - 0x00 interrupt mask. 0x04 direction. 0x08 output level. 0x0C trigger kind. 0x10 edge polarity. 0x14 level polarity.
  - 0x18 sleep mask. 0x1C sleep level. 0x20 fault level. 0x24 status. 0x28 peripheral select. 0x2C sleep config (bit 1). 0x30 pin view (read-only).
  - A write takes effect at the next clock edge, and reads are combinational.
  - An address with bits [1:0] not equal to 00 ignores writes and reads zero. Unmapped word addresses also read zero.
- R3: `pin_oe` equals the direction register, where 1 means output. In normal mode a pin drives its output-register bit. When its peripheral-select bit is 1, it drives its `alt_in` bit instead.
- R4: Sleep overrides apply when `sleep_req` is 1, or when sleep config bit 1 (autosleep) is 1. During a sleep override, a pin whose sleep-mask bit is 0 drives its sleep-level bit. A pin whose sleep-mask bit is 1 keeps its normal level.
- R5: When `batt_fault` is 1, every pin drives its fault-level bit. This takes priority over sleep and over normal mode.
- R6: The pin view register returns `pin_in` as sampled two clock edges earlier.
- R7: A trigger-kind bit of 1 selects edge detection. An edge-polarity bit of 1 means a rising edge and 0 means a falling edge. The status bit reads 1 three clock edges after the pin changes, and the opposite edge sets nothing.
- R8: A trigger-kind bit of 0 selects level detection. A level-polarity bit of 1 detects a high pin and 0 detects a low pin. The status bit is set on every edge while the synchronised pin matches.
- R9: Writing 1 to a status bit clears it, and writing 0 leaves it unchanged. If an event is present in the same cycle, the bit stays 1, so a level bit cannot be cleared while its condition holds.
- R10: `irq` is the combinational OR of the status bits whose mask bit is 0.
- R11: For the first three clock edges after reset the detectors are idle, so no status bit sets from synchroniser contents that predate reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 6 | Byte address of the register |
| reg_wdata | input | 16 | Write data |
| reg_rdata | output | 16 | Read data for `reg_addr` |
| pin_in | input | 16 | Pad input levels (asynchronous) |
| alt_in | input | 16 | Peripheral levels for pins handed to a peripheral |
| sleep_req | input | 1 | Sleep mode request |
| batt_fault | input | 1 | Battery fault indication |
| pin_out | output | 16 | Pad output levels |
| pin_oe | output | 16 | Pad output enables |
| irq | output | 1 | Bank interrupt |

## Verification
The assertions assume that `reg_we` and `reg_addr` are stable around the clock edge. They also assume that a status write is an ordinary cycle, so a clear-all with no pending event must leave the status empty one edge later. The stimulus drives every input at the falling clock edge and holds `pin_in` steady for at least three edges before sampling. The edge and level checks therefore always see a value that has settled through the synchroniser. Pin changes are applied one pin at a time, which keeps each expected status word unambiguous.

// File: rtl/gib_pkg.sv
package gib_pkg;
  localparam int ADDR_W = 6;

  // word index = byte address [5:2]
  typedef enum logic [3:0] {
    RI_IMASK = 4'd0,
    RI_DIR   = 4'd1,
    RI_OUT   = 4'd2,
    RI_TKIND = 4'd3,
    RI_EPOL  = 4'd4,
    RI_LPOL  = 4'd5,
    RI_SMASK = 4'd6,
    RI_SLVL  = 4'd7,
    RI_FLVL  = 4'd8,
    RI_STAT  = 4'd9,
    RI_ALT   = 4'd10,
    RI_SCFG  = 4'd11,
    RI_PINV  = 4'd12
  } reg_idx_e;
endpackage

// File: rtl/gib_regs.sv
module gib_regs
  import gib_pkg::*;
#(
  parameter int N = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              reg_we,
  input  logic [ADDR_W-1:0] reg_addr,
  input  logic [N-1:0]      reg_wdata,
  output logic [N-1:0]      reg_rdata,
  input  logic [N-1:0]      stat_q,
  input  logic [N-1:0]      pin_sync,
  output logic [N-1:0]      mask_q,
  output logic [N-1:0]      dir_q,
  output logic [N-1:0]      out_q,
  output logic [N-1:0]      tkind_q,
  output logic [N-1:0]      epol_q,
  output logic [N-1:0]      lpol_q,
  output logic [N-1:0]      smask_q,
  output logic [N-1:0]      slvl_q,
  output logic [N-1:0]      flvl_q,
  output logic [N-1:0]      alt_q,
  output logic              auto_q,
  output logic [N-1:0]      stat_clr
);
  logic [3:0] idx;
  logic       word_ok;

  assign idx     = reg_addr[5:2];
  assign word_ok = (reg_addr[1:0] == 2'b00);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mask_q  <= '1;
      dir_q   <= '0;
      out_q   <= '0;
      tkind_q <= '0;
      epol_q  <= '0;
      lpol_q  <= '0;
      smask_q <= '0;
      slvl_q  <= '0;
      flvl_q  <= '0;
      alt_q   <= '0;
      auto_q  <= 1'b0;
    end else if (reg_we && word_ok) begin
      case (idx)
        RI_IMASK: mask_q  <= reg_wdata;
        RI_DIR:   dir_q   <= reg_wdata;
        RI_OUT:   out_q   <= reg_wdata;
        RI_TKIND: tkind_q <= reg_wdata;
        RI_EPOL:  epol_q  <= reg_wdata;
        RI_LPOL:  lpol_q  <= reg_wdata;
        RI_SMASK: smask_q <= reg_wdata;
        RI_SLVL:  slvl_q  <= reg_wdata;
        RI_FLVL:  flvl_q  <= reg_wdata;
        RI_ALT:   alt_q   <= reg_wdata;
        RI_SCFG:  auto_q  <= reg_wdata[1];
        default:  ;
      endcase
    end
  end

  assign stat_clr = (reg_we && word_ok && idx == RI_STAT) ? reg_wdata : '0;

  always_comb begin
    reg_rdata = '0;
    if (word_ok) begin
      case (idx)
        RI_IMASK: reg_rdata = mask_q;
        RI_DIR:   reg_rdata = dir_q;
        RI_OUT:   reg_rdata = out_q;
        RI_TKIND: reg_rdata = tkind_q;
        RI_EPOL:  reg_rdata = epol_q;
        RI_LPOL:  reg_rdata = lpol_q;
        RI_SMASK: reg_rdata = smask_q;
        RI_SLVL:  reg_rdata = slvl_q;
        RI_FLVL:  reg_rdata = flvl_q;
        RI_STAT:  reg_rdata = stat_q;
        RI_ALT:   reg_rdata = alt_q;
        RI_SCFG:  reg_rdata = {{(N-2){1'b0}}, auto_q, 1'b0};
        RI_PINV:  reg_rdata = pin_sync;
        default:  reg_rdata = '0;
      endcase
    end
  end

  // R9
  stat_write_isolated_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_we && word_ok && idx == RI_STAT) |=> ($stable(dir_q) && $stable(out_q) && $stable(mask_q)));
endmodule

// File: rtl/gib_detect.sv
module gib_detect #(
  parameter int N = 16
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] pin_in,
  input  logic [N-1:0] tkind_q,
  input  logic [N-1:0] epol_q,
  input  logic [N-1:0] lpol_q,
  input  logic [N-1:0] mask_q,
  input  logic [N-1:0] stat_clr,
  output logic [N-1:0] pin_sync,
  output logic [N-1:0] stat_q,
  output logic         irq
);
  localparam int WARM = 3;
  localparam int WW   = $clog2(WARM + 1);

  logic [N-1:0]  meta_q, sync_q, prev_q, evt;
  logic [WW-1:0] warm_q;
  logic          armed;

  assign armed = (warm_q == WW'(WARM));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      meta_q <= '0;
      sync_q <= '0;
      prev_q <= '0;
      warm_q <= '0;
    end else begin
      meta_q <= pin_in;
      sync_q <= meta_q;
      prev_q <= sync_q;
      if (!armed) warm_q <= warm_q + WW'(1);
    end
  end

  for (genvar g = 0; g < N; g++) begin : g_pin
    logic rise, fall, edge_hit, lvl_hit;
    assign rise     = sync_q[g] & ~prev_q[g];
    assign fall     = ~sync_q[g] & prev_q[g];
    assign edge_hit = epol_q[g] ? rise : fall;
    assign lvl_hit  = (sync_q[g] == lpol_q[g]);
    assign evt[g]   = armed & (tkind_q[g] ? edge_hit : lvl_hit);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) stat_q <= '0;
    else        stat_q <= (stat_q & ~stat_clr) | evt;
  end

  assign pin_sync = sync_q;
  assign irq      = |(stat_q & ~mask_q);

  // R7
  stat_set_by_event_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (stat_q & ~$past(stat_q) & ~$past(evt)) == '0);
  // R9
  clear_all_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (stat_clr == '1 && evt == '0) |=> (stat_q == '0));
  // R10
  masked_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (&mask_q) |-> !irq);
  // R11
  warmup_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !armed |-> (evt == '0));
endmodule

// File: rtl/gib_outmux.sv
module gib_outmux #(
  parameter int N = 16
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] dir_q,
  input  logic [N-1:0] out_q,
  input  logic [N-1:0] alt_q,
  input  logic [N-1:0] alt_in,
  input  logic [N-1:0] smask_q,
  input  logic [N-1:0] slvl_q,
  input  logic [N-1:0] flvl_q,
  input  logic         auto_q,
  input  logic         sleep_req,
  input  logic         batt_fault,
  output logic [N-1:0] pin_out,
  output logic [N-1:0] pin_oe
);
  logic sleep_on;
  assign sleep_on = sleep_req | auto_q;

  for (genvar g = 0; g < N; g++) begin : g_mux
    logic norm, use_slp;
    assign norm       = alt_q[g] ? alt_in[g] : out_q[g];
    assign use_slp    = sleep_on & ~smask_q[g];
    assign pin_out[g] = batt_fault ? flvl_q[g] : (use_slp ? slvl_q[g] : norm);
  end

  assign pin_oe = dir_q;

  // R5
  fault_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
    batt_fault |-> (pin_out == flvl_q));
  // R4
  sleep_unmasked_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!batt_fault && sleep_req) |-> ((pin_out & ~smask_q) == (slvl_q & ~smask_q)));
endmodule

// File: rtl/gpio_irq_bank.sv
module gpio_irq_bank
  import gib_pkg::*;
#(
  parameter int N = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              reg_we,
  input  logic [ADDR_W-1:0] reg_addr,
  input  logic [N-1:0]      reg_wdata,
  output logic [N-1:0]      reg_rdata,
  input  logic [N-1:0]      pin_in,
  input  logic [N-1:0]      alt_in,
  input  logic              sleep_req,
  input  logic              batt_fault,
  output logic [N-1:0]      pin_out,
  output logic [N-1:0]      pin_oe,
  output logic              irq
);
  logic [N-1:0] mask_q, dir_q, out_q, tkind_q, epol_q, lpol_q;
  logic [N-1:0] smask_q, slvl_q, flvl_q, alt_q, stat_q, stat_clr, pin_sync;
  logic         auto_q;

  gib_regs #(.N(N)) u_regs (
    .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .stat_q(stat_q),
    .pin_sync(pin_sync), .mask_q(mask_q), .dir_q(dir_q), .out_q(out_q),
    .tkind_q(tkind_q), .epol_q(epol_q), .lpol_q(lpol_q), .smask_q(smask_q),
    .slvl_q(slvl_q), .flvl_q(flvl_q), .alt_q(alt_q), .auto_q(auto_q),
    .stat_clr(stat_clr)
  );

  gib_detect #(.N(N)) u_det (
    .clk(clk), .rst_n(rst_n), .pin_in(pin_in), .tkind_q(tkind_q),
    .epol_q(epol_q), .lpol_q(lpol_q), .mask_q(mask_q), .stat_clr(stat_clr),
    .pin_sync(pin_sync), .stat_q(stat_q), .irq(irq)
  );

  gib_outmux #(.N(N)) u_mux (
    .clk(clk), .rst_n(rst_n), .dir_q(dir_q), .out_q(out_q), .alt_q(alt_q),
    .alt_in(alt_in), .smask_q(smask_q), .slvl_q(slvl_q), .flvl_q(flvl_q),
    .auto_q(auto_q), .sleep_req(sleep_req), .batt_fault(batt_fault),
    .pin_out(pin_out), .pin_oe(pin_oe)
  );
endmodule

// File: tb/sim_gpio_irq_bank.sv
`timescale 1ns/1ps
module sim_gpio_irq_bank;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        reg_we = 1'b0;
  logic [5:0]  reg_addr = '0;
  logic [15:0] reg_wdata = '0;
  logic [15:0] reg_rdata;
  logic [15:0] pin_in = 16'hFFFF;
  logic [15:0] alt_in = '0;
  logic        sleep_req = 1'b0;
  logic        batt_fault = 1'b0;
  logic [15:0] pin_out, pin_oe;
  logic        irq;

  int n_chk = 0;
  int n_bad = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  gpio_irq_bank u0 (
    .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .pin_in(pin_in),
    .alt_in(alt_in), .sleep_req(sleep_req), .batt_fault(batt_fault),
    .pin_out(pin_out), .pin_oe(pin_oe), .irq(irq)
  );

  typedef struct packed {
    logic [15:0] o, a, ai, sm, so, fo;
    logic        slp, flt, aut;
    logic [15:0] exp;
  } vec_t;

  // output, alt select, alt_in, sleep mask, sleep level, fault level, sleep_req, fault, autosleep, expected
  localparam vec_t VEC [7] = '{
    '{16'h00F0, 16'h0000, 16'hFFFF, 16'h0000, 16'h0F00, 16'hA5A5, 1'b0, 1'b0, 1'b0, 16'h00F0}, // R3
    '{16'h00F0, 16'h00FF, 16'h0033, 16'h0000, 16'h0F00, 16'hA5A5, 1'b0, 1'b0, 1'b0, 16'h0033}, // R3
    '{16'h00F0, 16'h0000, 16'h0000, 16'h0000, 16'h0F00, 16'hA5A5, 1'b1, 1'b0, 1'b0, 16'h0F00}, // R4
    '{16'hF0F0, 16'h0000, 16'h0000, 16'hFF00, 16'h0F0F, 16'hA5A5, 1'b1, 1'b0, 1'b0, 16'hF00F}, // R4
    '{16'hF0F0, 16'h0000, 16'h0000, 16'hFF00, 16'h0F0F, 16'hA5A5, 1'b1, 1'b1, 1'b0, 16'hA5A5}, // R5
    '{16'hFFFF, 16'h0000, 16'h0000, 16'h0000, 16'h1234, 16'h0000, 1'b0, 1'b0, 1'b1, 16'h1234}, // R4
    '{16'hFFFF, 16'h0000, 16'h0000, 16'h00FF, 16'h1234, 16'h0000, 1'b0, 1'b0, 1'b1, 16'h12FF}  // R4
  };

  task automatic chk(input string req, input logic [15:0] act, input logic [15:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [5:0] a, input logic [15:0] d);
    reg_addr = a; reg_wdata = d; reg_we = 1'b1;
    @(negedge clk);
    reg_we = 1'b0;
  endtask

  task automatic rd(input logic [5:0] a, output logic [15:0] d);
    reg_addr = a;
    #0.5;
    d = reg_rdata;
  endtask

  task automatic wait_n(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic wrap_up;
    if (!done) begin
      done = 1'b1;
      $display("  End of test - %0d assertions evaluated, %0d failures", n_chk, n_bad);
      $finish;
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_chk++; n_bad++;
    $display("FAIL watchdog actual=hung expected=done");
    wrap_up();
  end

  initial begin
    logic [15:0] v;
    wait_n(4);
    // R1 during reset
    chk("R1 pin_out", pin_out, 16'h0000);
    chk("R1 pin_oe", pin_oe, 16'h0000);
    chk("R1 irq", {15'd0, irq}, 16'h0000);
    rst_n = 1'b1;
    wait_n(1);
    rd(6'h00, v); chk("R1 mask reset", v, 16'hFFFF);
    rd(6'h08, v); chk("R1 output reset", v, 16'h0000);
    wait_n(6);
    // R11: pins high, default low-level detect, stale reset contents must not set status
    rd(6'h24, v); chk("R11 status after warm-up", v, 16'h0000);

    // table-driven output multiplexing
    wr(6'h04, 16'hFFFF);
    chk("R3 pin_oe", pin_oe, 16'hFFFF);
    for (int i = 0; i < 7; i++) begin
      wr(6'h08, VEC[i].o);
      wr(6'h28, VEC[i].a);
      wr(6'h18, VEC[i].sm);
      wr(6'h1C, VEC[i].so);
      wr(6'h20, VEC[i].fo);
      wr(6'h2C, {14'd0, VEC[i].aut, 1'b0});
      alt_in = VEC[i].ai; sleep_req = VEC[i].slp; batt_fault = VEC[i].flt;
      wait_n(1);
      chk($sformatf("R3/R4/R5 vector %0d", i), pin_out, VEC[i].exp);
    end
    sleep_req = 1'b0; batt_fault = 1'b0;
    wr(6'h2C, 16'h0000);

    // R2 misaligned and unmapped accesses
    wr(6'h05, 16'h0000);
    chk("R2 misaligned write ignored", pin_oe, 16'hFFFF);
    rd(6'h05, v); chk("R2 misaligned read", v, 16'h0000);
    rd(6'h34, v); chk("R2 unmapped read", v, 16'h0000);

    // edge configuration: pin0 rising, pin1 falling, others low level
    wr(6'h0C, 16'h0003);
    wr(6'h10, 16'h0001);
    pin_in[0] = 1'b0; wait_n(3);
    rd(6'h24, v); chk("R7 falling ignored in rising mode", v, 16'h0000);
    pin_in[0] = 1'b1; wait_n(3);
    rd(6'h24, v); chk("R7 rising edge", v, 16'h0001);
    chk("R10 masked irq", {15'd0, irq}, 16'h0000);
    wr(6'h00, 16'hFFFE);
    chk("R10 unmasked irq", {15'd0, irq}, 16'h0001);
    wr(6'h24, 16'h0001);
    rd(6'h24, v); chk("R9 clear edge bit", v, 16'h0000);
    chk("R10 irq after clear", {15'd0, irq}, 16'h0000);
    pin_in[1] = 1'b0; wait_n(3);
    rd(6'h24, v); chk("R7 falling edge", v, 16'h0002);
    wr(6'h24, 16'h0002);
    rd(6'h24, v); chk("R9 clear falling bit", v, 16'h0000);

    // R6 pin view latency, R8 low level
    pin_in[3] = 1'b0;
    wait_n(1);
    rd(6'h30, v); chk("R6 pin view after one edge", v, 16'hFFFD);
    wait_n(1);
    rd(6'h30, v); chk("R6 pin view after two edges", v, 16'hFFF5);
    wait_n(1);
    rd(6'h24, v); chk("R8 low level", v, 16'h0008);
    wr(6'h24, 16'h0008);
    rd(6'h24, v); chk("R9 level holds against clear", v, 16'h0008);
    pin_in[3] = 1'b1; wait_n(3);
    wr(6'h24, 16'h0008);
    rd(6'h24, v); chk("R9 level clears after release", v, 16'h0000);

    // R8 high level on pin2 (pin is high)
    wr(6'h14, 16'h0004);
    wait_n(1);
    rd(6'h24, v); chk("R8 high level", v, 16'h0004);
    chk("R10 bit2 masked", {15'd0, irq}, 16'h0000);
    wr(6'h00, 16'hFFFB);
    chk("R10 bit2 unmasked", {15'd0, irq}, 16'h0001);
    wr(6'h24, 16'h0000);
    rd(6'h24, v); chk("R9 zero write keeps bit", v, 16'h0004);

    wrap_up();
  end
endmodule